// File: doc/BRIEF.md
# I2C Target with Hard Transaction Timeout

This block is an I2C target (slave) that runs from a fast system clock and oversamples the bus lines. It recognises START, repeated START and STOP conditions. It answers one fixed 7-bit address and serves byte writes and reads to a small internal register file. A write transaction carries the register pointer in its first data byte and register data after that. A read returns bytes starting at the current pointer, and the pointer advances after every byte. SDA is never driven high: the block only asserts an active-low open-drain enable.

A transaction watchdog arms on a START seen from an idle bus and counts system-clock cycles. Repeated STARTs inside the same transaction do not restart it, so long chained transfers are the ones most likely to hit the limit. When the count runs out, the target drops off the bus at once, in whatever bit or acknowledge it was in. If it was holding SDA low while SCL was high, the release makes a STOP on the bus. Otherwise the master sees 1s: read bytes come back as 0xFF, and write bytes are not acknowledged. After a timeout the target ignores the bus until a real STOP, and then accepts a new START normally. A one-cycle pulse and a sticky flag report the timeout.

Top module: `i2c_tgt_wdog`

## Requirements
- R1: SCL and SDA each pass through a two-flop synchronizer and one more sample stage. A START is SDA falling while SCL is high; a STOP is SDA rising while SCL is high.
- R2: After a START, the 8-bit address byte (7 address bits MSB first, then R/W with 1 = read) is acknowledged by pulling SDA low for the ninth clock only when the address equals TGT_ADDR. Any other address gets no acknowledge, and the target leaves SDA alone until the next START or STOP.
- R3: In a write, the first data byte loads the pointer from its low log2(DEPTH) bits. Each later byte is stored at the pointer, and the pointer then increments modulo DEPTH. Every data byte is acknowledged.
- R4: In a read, bytes are returned MSB first from the register at the pointer, and the pointer increments modulo DEPTH after each byte. Output continues while the master acknowledges (SDA low in the ninth clock) and stops after a master NACK.
- R5: The SDA pull-down enable changes only while SCL is low. The only exception is the release on timeout.
- R6: The watchdog arms on a START from the idle bus and expires WDOG_LIMIT cycles later (default 2^18 + 8). Repeated STARTs do not restart it.
- R7: On expiry the pull-down is released within one cycle, the timeout pulse is high for exactly one cycle, and the sticky flag sets and stays set until reset. After reset, the pull-down is off and both the pulse and the flag are low.
- R8: If expiry comes while the target holds SDA low with SCL high, SDA rises while SCL is still high, which forms a STOP on the bus.
- R9: After expiry, every further read bit is 1 (bytes read as 0xFF), later write bytes are not acknowledged, and those bytes are not stored.
- R10: After expiry the target ignores all activity, START included, until a STOP. After that STOP, a new START and address are served normally.
- R11: A STOP disarms and clears the watchdog, so separate transactions whose total length exceeds WDOG_LIMIT do not time out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level as seen on the bus |
| sda_i | input | 1 | SDA level as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |
| tmo_pulse_o | output | 1 | One-cycle pulse when the watchdog expires |
| tmo_flag_o | output | 1 | Sticky timeout flag, cleared only by reset |

## Verification
Assertions check on every cycle that the pull-down enable moves only while the sampled SCL is low, unless a timeout is releasing it. They also check that a repeated START leaves the watchdog counting, that a STOP disarms it, that the timed-out state never drives SDA and ignores START, and that the timeout pulse lasts one cycle. Only the bench scenarios can show the end-to-end effects: address matching over all 128 addresses, pointer wrap on reads and writes, and the measured distance from the first START to expiry across chained repeated STARTs. They also show the 0xFF reads and NACKed writes after expiry, that NACKed bytes are not stored, and the STOP that the bus sees when the release happens with SCL high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_MACK,
    ST_SKIP,
    ST_TMO
  } tgt_state_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] scl_sh;
  logic [CHAIN-1:0] sda_sh;
  logic             scl_cur, scl_prev, sda_cur, sda_prev;

  // Idle bus is high: reset the chains to 1 so no false condition appears.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[CHAIN-2:0], scl_i};
      sda_sh <= {sda_sh[CHAIN-2:0], sda_i};
    end
  end

  assign scl_cur  = scl_sh[SYNC_STAGES-1];
  assign sda_cur  = sda_sh[SYNC_STAGES-1];
  assign scl_prev = scl_sh[SYNC_STAGES];
  assign sda_prev = sda_sh[SYNC_STAGES];

  always_comb begin
    evt.scl   = scl_cur;
    evt.sda   = sda_cur;
    evt.start = scl_cur & scl_prev & sda_prev & ~sda_cur;
    evt.stop  = scl_cur & scl_prev & ~sda_prev & sda_cur;
    evt.rise  = ~scl_prev & scl_cur;
    evt.fall  = scl_prev & ~scl_cur;
  end

endmodule

// File: rtl/i2c_txn_wdog.sv
module i2c_txn_wdog #(
  parameter int unsigned LIMIT = (1 << 18) + 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  input  logic block,
  output logic expire
);

  localparam int CW = $clog2(LIMIT + 1);

  logic          armed;
  logic [CW-1:0] cnt;

  assign expire = armed && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (stop) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (expire) begin
      armed <= 1'b0;
    end else if (armed) begin
      cnt <= cnt + CW'(1);
    end else if (start && !block) begin
      armed <= 1'b1;
      cnt   <= '0;
    end
  end

  AST_WD_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (armed && start && !stop && !expire) |=> (cnt == $past(cnt) + CW'(1))); // R6
  AST_WD_BOUND: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt < CW'(LIMIT))); // R6
  AST_WD_STOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    stop |=> !armed); // R11

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2c_tgt_wdog.sv
module i2c_tgt_wdog
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  TGT_ADDR    = 7'h42,
  parameter int          DEPTH       = 16,
  parameter int unsigned WDOG_LIMIT  = (1 << 18) + 8,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic tmo_pulse_o,
  output logic tmo_flag_o
);

  localparam int PW = $clog2(DEPTH);

  bus_evt_t          ev;
  tgt_state_e        state;
  logic              expire;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg, txreg, rdata, wdata;
  logic [PW-1:0]     ptr, waddr;
  logic              we, rw, first, mack;
  logic              sda_oe, tmo_pulse, tmo_flag;

  i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt(ev)
  );

  i2c_txn_wdog #(.LIMIT(WDOG_LIMIT)) u_wd (
    .clk(clk), .rst(rst), .start(ev.start), .stop(ev.stop),
    .block(state == ST_TMO), .expire(expire)
  );

  i2c_tgt_regs #(.DEPTH(DEPTH), .W(BYTE_W)) u_regs (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      ptr       <= '0;
      waddr     <= '0;
      wdata     <= '0;
      we        <= 1'b0;
      rw        <= 1'b0;
      first     <= 1'b0;
      mack      <= 1'b1;
      sda_oe    <= 1'b0;
      tmo_pulse <= 1'b0;
      tmo_flag  <= 1'b0;
    end else begin
      we        <= 1'b0;
      tmo_pulse <= 1'b0;
      if (expire) begin
        // Abrupt drop-off: release SDA whatever the bus phase.
        state     <= ST_TMO;
        sda_oe    <= 1'b0;
        tmo_pulse <= 1'b1;
        tmo_flag  <= 1'b1;
      end else if (state == ST_TMO) begin
        if (ev.stop) state <= ST_IDLE;
      end else if (ev.stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (ev.start) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (ev.rise) begin
              shreg  <= {shreg[BYTE_W-2:0], ev.sda};
              bitcnt <= bitcnt + 4'd1;
            end else if (ev.fall && bitcnt == 4'd8) begin
              if (shreg[BYTE_W-1:1] == TGT_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev.fall) begin
              bitcnt <= '0;
              if (rw) begin
                txreg  <= rdata;
                sda_oe <= ~rdata[BYTE_W-1];
                state  <= ST_RD_BYTE;
              end else begin
                sda_oe <= 1'b0;
                first  <= 1'b1;
                state  <= ST_WR_BYTE;
              end
            end
          end
          ST_WR_BYTE: begin
            if (ev.rise) begin
              shreg  <= {shreg[BYTE_W-2:0], ev.sda};
              bitcnt <= bitcnt + 4'd1;
            end else if (ev.fall && bitcnt == 4'd8) begin
              sda_oe <= 1'b1;
              state  <= ST_WR_ACK;
              if (first) begin
                ptr   <= shreg[PW-1:0];
                first <= 1'b0;
              end else begin
                we    <= 1'b1;
                waddr <= ptr;
                wdata <= shreg;
                ptr   <= ptr + PW'(1);
              end
            end
          end
          ST_WR_ACK: begin
            if (ev.fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (ev.rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (ev.fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + PW'(1);
                state  <= ST_RD_MACK;
              end else begin
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txreg[BYTE_W-2];
              end
            end
          end
          ST_RD_MACK: begin
            if (ev.rise) begin
              mack <= ev.sda;
            end else if (ev.fall) begin
              if (!mack) begin
                txreg  <= rdata;
                sda_oe <= ~rdata[BYTE_W-1];
                bitcnt <= '0;
                state  <= ST_RD_BYTE;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = sda_oe;
  assign tmo_pulse_o = tmo_pulse;
  assign tmo_flag_o  = tmo_flag;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(ev.scl)); // R5
  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_oe) && !tmo_pulse) |-> !$past(ev.scl)); // R5
  AST_TMO_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TMO) |-> !sda_oe); // R9
  AST_TMO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |=> !tmo_pulse); // R7
  AST_TMO_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TMO && ev.start && !expire) |=> (state == ST_TMO)); // R10
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_oe); // R2

endmodule

// File: tb/sim_i2c_tgt_wdog.sv
`timescale 1ns/1ps
module sim_i2c_tgt_wdog;

  localparam logic [6:0] TGT   = 7'h42;
  localparam int         LIMIT = 4000;
  localparam int         Q     = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, tmo_pulse, tmo_flag;
  wire  scl_w = m_scl;
  wire  sda_w = m_sda & ~sda_oe;

  int nchk = 0, nfail = 0;
  int cyc = 0, t_start = 0, pulse_cyc = 0;
  int npulse = 0, pulse_wide = 0, oe_bad = 0;
  logic pulse_prev = 1'b0, oe_prev = 1'b0;
  bit done = 1'b0;
  logic [7:0] mdl [16];

  always #2.5 clk = ~clk;

  i2c_tgt_wdog #(.TGT_ADDR(TGT), .DEPTH(16), .WDOG_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_w), .sda_i(sda_w),
    .sda_oe_o(sda_oe), .tmo_pulse_o(tmo_pulse), .tmo_flag_o(tmo_flag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (tmo_pulse) begin
        npulse++;
        pulse_cyc = cyc;
        if (pulse_prev) pulse_wide++;
      end
      pulse_prev = tmo_pulse;
      if (sda_oe != oe_prev && scl_w && !tmo_pulse) oe_bad++;
      oe_prev = sda_oe;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start(input bit fresh);
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b0;
    if (fresh) t_start = cyc;
    w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; w(Q);
    m_scl = 1'b1; w(Q);
    m_sda = 1'b1; w(2*Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q);
      m_scl = 1'b1; w(2*Q);
      m_scl = 1'b0; w(Q);
    end
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    ack = (sda_w == 1'b0);
    w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic read_byte(input bit nack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(Q);
      m_scl = 1'b1; w(Q);
      d = {d[6:0], sda_w};
      w(Q);
      m_scl = 1'b0; w(Q);
    end
    m_sda = nack; w(Q);
    m_scl = 1'b1; w(2*Q);
    m_scl = 1'b0; w(Q);
    m_sda = 1'b1;
  endtask

  // Fill all 16 registers from pointer 0 with f(i) = (i*mul+add) mod 256.
  task automatic fill(input int mul, input int add);
    bit a;
    i2c_start(1);
    write_byte({TGT, 1'b0}, a);
    write_byte(8'd0, a);
    for (int i = 0; i < 16; i++) begin
      mdl[i] = 8'((i * mul + add) & 255);
      write_byte(mdl[i], a);
      check(a, "R3 data ack", a, 1);
    end
    i2c_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    int first_nack, acks, nacks, lat, f;
    bit mono;

    w(5);
    rst = 1'b0;
    w(3);
    // R7: reset state
    check(sda_oe == 1'b0, "R7 reset oe", sda_oe, 0);
    check(tmo_pulse == 1'b0, "R7 reset pulse", tmo_pulse, 0);
    check(tmo_flag == 1'b0, "R7 reset flag", tmo_flag, 0);

    // R1 / R2: address sweep over all 128 addresses
    for (int ad = 0; ad < 128; ad++) begin
      i2c_start(1);
      write_byte({7'(ad), 1'b0}, a);
      check(a == (ad == int'(TGT)), "R2 R1 address ack", a, ad == int'(TGT));
      i2c_stop();
    end

    // R3 / R4: full write then full sequential read
    fill(37, 11);
    i2c_start(1);
    write_byte({TGT, 1'b0}, a);
    write_byte(8'd0, a);
    i2c_start(0);
    write_byte({TGT, 1'b1}, a);
    check(a, "R4 read addr ack", a, 1);
    for (int i = 0; i < 16; i++) begin
      read_byte(i == 15, d);
      check(d == mdl[i], "R4 read data", d, mdl[i]);
    end
    i2c_stop();

    // R3 write wrap: pointer 15, two bytes land in 15 and 0
    i2c_start(1);
    write_byte({TGT, 1'b0}, a);
    write_byte(8'd15, a);
    write_byte(8'hA5, a);
    write_byte(8'h5A, a);
    i2c_stop();
    mdl[15] = 8'hA5;
    mdl[0]  = 8'h5A;
    // R4 read wrap from 14
    i2c_start(1);
    write_byte({TGT, 1'b0}, a);
    write_byte(8'd14, a);
    i2c_start(0);
    write_byte({TGT, 1'b1}, a);
    for (int i = 0; i < 4; i++) begin
      read_byte(i == 3, d);
      check(d == mdl[(14 + i) % 16], "R3 R4 wrap data", d, mdl[(14 + i) % 16]);
    end
    i2c_stop();

    // R11: many short transactions, far longer than LIMIT in total, no timeout
    check(npulse == 0 && tmo_flag == 1'b0, "R11 no timeout across STOPs", npulse, 0);

    // Long write transaction chained with repeated STARTs (R6, R7, R9, R10)
    i2c_start(1);
    write_byte({TGT, 1'b0}, a);
    write_byte(8'd4, a);
    for (int k = 0; k < 6; k++) begin
      i2c_start(0);
      write_byte({TGT, 1'b0}, a);
      write_byte(8'd4, a);
    end
    first_nack = -1; acks = 0; nacks = 0; mono = 1'b1;
    for (int j = 0; j < 12; j++) begin
      write_byte(8'(8'hC0 + j), a);
      if (a) begin
        acks++;
        if (first_nack >= 0) mono = 1'b0;
      end else begin
        nacks++;
        if (first_nack < 0) first_nack = j;
      end
    end
    check(mono && acks >= 3 && nacks >= 3, "R9 write acks then NACKs", acks, 7);
    check(npulse == 1, "R7 one pulse", npulse, 1);
    check(tmo_flag == 1'b1, "R7 sticky flag", tmo_flag, 1);
    lat = pulse_cyc - t_start;
    check(lat >= LIMIT + 1 && lat <= LIMIT + 5, "R6 latency from first START", lat, LIMIT + 3);
    i2c_start(0);
    write_byte({TGT, 1'b1}, a);
    check(!a, "R10 START ignored after timeout", a, 0);
    i2c_stop();
    for (int j = 0; j < 12; j++)
      if (j < first_nack) mdl[4 + j] = 8'(8'hC0 + j);
    // Readback after STOP: served normally (R10); NACKed bytes not stored (R9)
    i2c_start(1);
    write_byte({TGT, 1'b0}, a);
    check(a, "R10 new START accepted", a, 1);
    write_byte(8'd4, a);
    i2c_start(0);
    write_byte({TGT, 1'b1}, a);
    for (int j = 0; j < 12; j++) begin
      read_byte(j == 11, d);
      if (j != first_nack)
        check(d == mdl[4 + j], "R9 R3 stored data", d, mdl[4 + j]);
    end
    i2c_stop();

    // R8: expiry while driving a 0 bit with SCL held high
    i2c_start(1);
    write_byte({TGT, 1'b0}, a);
    write_byte(8'd3, a);
    write_byte(8'h00, a);
    i2c_stop();
    mdl[3] = 8'h00;
    i2c_start(1);
    write_byte({TGT, 1'b0}, a);
    write_byte(8'd3, a);
    i2c_start(0);
    write_byte({TGT, 1'b1}, a);
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    check(sda_w == 1'b0, "R8 target holds 0 bit", sda_w, 0);
    for (int i = 0; i < 2 * LIMIT && npulse < 2; i++) w(1);
    w(4);
    check(npulse == 2, "R7 second pulse", npulse, 2);
    check(sda_w == 1'b1 && scl_w == 1'b1, "R8 release forms STOP", {scl_w, sda_w}, 3);
    lat = pulse_cyc - t_start;
    check(lat >= LIMIT + 1 && lat <= LIMIT + 5, "R6 latency with hold", lat, LIMIT + 3);
    m_scl = 1'b0; w(Q);
    i2c_start(1);
    write_byte({TGT, 1'b0}, a);
    check(a, "R10 after bus STOP", a, 1);
    i2c_stop();

    // R9: long read; data until expiry, then 0xFF
    fill(53, 7);
    i2c_start(1);
    write_byte({TGT, 1'b0}, a);
    write_byte(8'd0, a);
    i2c_start(0);
    write_byte({TGT, 1'b1}, a);
    f = -1; mono = 1'b1;
    for (int i = 0; i < 30; i++) begin
      read_byte(i == 29, d);
      if (f < 0) begin
        if (d != mdl[i % 16]) f = i;
      end else if (d != 8'hFF) mono = 1'b0;
    end
    i2c_stop();
    check(f >= 16 && f <= 22, "R9 R4 first bad read index", f, 19);
    check(mono, "R9 reads are 0xFF after expiry", mono, 1);
    check(npulse == 3, "R7 third pulse", npulse, 3);

    check(oe_bad == 0, "R5 oe changes with SCL low", oe_bad, 0);
    check(pulse_wide == 0, "R7 pulse width one", pulse_wide, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule